// File: doc/BRIEF.md
# Dual 16-bit Reference Timer Pair

Two independent 16-bit up-counters sit behind a small word-addressed register port. Each counter takes its count clock from a selectable source: a tick input, every clock, or every sixteenth clock. The selected tick then passes through a primary and a secondary 8-bit prescaler. The pair shares one configuration byte, which holds an enable (reset-release) bit and a stop bit for each timer.

Every timer has its own mode, reference, counter, event and primary-prescale registers. When a count tick moves the counter onto the reference value, the timer sets a sticky event flag. If the mode enables it, the timer also raises a level interrupt that stays high until software clears the flag. In restart mode the counter goes back to zero after the match. Otherwise it keeps counting and wraps past 0xFFFF.

To program a timer, software pulses its enable low to zero the counter and prescalers. It then sets enable with stop, writes the timer's registers, clears the events, and finally clears stop.

Top module: `dual_ref_timer`

## Requirements
- R1: After rst_ni is released, every register reads 0, both interrupts are low and both timers are held.
- R2: In the config byte, bit 0 enables timer 0 and bit 1 stops it. Bit 4 enables timer 1 and bit 5 stops it. While a timer's enable bit is 0, its counter and prescalers stay at zero and writes to its counter are ignored. Each timer's bits affect only that timer.
- R3: While a timer is enabled and its stop bit is 1, the counter and both prescalers hold their values. Counting resumes from the held prescaler phase when stop is cleared.
- R4: Mode bits 2:1 select the tick source: 00 is the tick input, 01 is every clock, 10 is every 16th clock, and 11 is no tick.
- R5: With P as primary prescale bits 7:0 and S as mode bits 15:8, the counter advances once per (P+1)*(S+1) source ticks. After release, the first increment comes one full period after release.
- R6: A count tick that leaves the counter equal to the reference sets event bit 1.
- R7: With mode bit 3 set, a count tick while the counter equals the reference loads 0, so the period is reference+1 ticks.
- R8: With mode bit 3 clear, the counter counts through the match and wraps from 0xFFFF to 0x0000.
- R9: The interrupt equals event bit 1 AND mode bit 4. It stays high until the event is cleared, and it stays low when bit 4 is 0 even if the event is set.
- R10: The event register is write-one-to-clear. Writing 1 in bit 1 clears the flag, and writing 0 there leaves it unchanged.
- R11: While enabled, a counter write loads the value, and it takes priority over a count tick in the same cycle.
- R12: Word address bit 3 selects the timer and bits 2:0 select the register: 0 config (timer 1 slot reads 0), 1 mode, 2 reference, 3 counter, 4 event, 5 prescale. Reads are combinational. Prescale bits 15:8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Word address |
| wdata_i | input | 16 | Write data (config uses bits 7:0) |
| rdata_o | output | 16 | Read data for addr_i |
| casc_tick_i | input | 2 | Per-timer external tick for source 00 |
| irq_o | output | 2 | Per-timer reference interrupt |

## Verification
The bench checks the counter value just before and just after each prescaled period boundary. A prescaler that counted to P instead of P+1 would show up as an early or late increment. The stop test freezes a timer in mid-period and then needs the increment exactly where the saved phase puts it, so a prescaler cleared on stop fails. The bench also presets the counter just below 0xFFFF to catch a free-running counter that saturates instead of wrapping, or that misses a match after the wrap. Separate tests look for an event clear that hits the wrong bit and for a write to one timer's config bits that disturbs the other timer.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int REG_W = 16;
  localparam int PS_W  = 8;
  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] REG_CFG  = 3'd0;
  localparam logic [SEL_W-1:0] REG_MODE = 3'd1;
  localparam logic [SEL_W-1:0] REG_REF  = 3'd2;
  localparam logic [SEL_W-1:0] REG_CNT  = 3'd3;
  localparam logic [SEL_W-1:0] REG_EVT  = 3'd4;
  localparam logic [SEL_W-1:0] REG_PSR  = 3'd5;

  localparam int EVT_REF_BIT  = 1;
  localparam int MODE_RESTART = 3;
  localparam int MODE_IRQ_EN  = 4;
  localparam int MODE_SPS_LO  = 8;

  typedef enum logic [1:0] {
    SRC_CASC = 2'b00,
    SRC_CLK  = 2'b01,
    SRC_SLOW = 2'b10,
    SRC_OFF  = 2'b11
  } src_e;
endpackage

// File: rtl/drt_prescaler.sv
module drt_prescaler import drt_pkg::*; #(
  parameter int SLOW_DIV = 16,
  localparam int SLOW_W  = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            hold_i,
  input  logic [1:0]      src_sel_i,
  input  logic            casc_tick_i,
  input  logic [PS_W-1:0] pri_div_i,
  input  logic [PS_W-1:0] sec_div_i,
  output logic            tick_o
);
  src_e              src;
  logic [SLOW_W-1:0] slow_q;
  logic [PS_W-1:0]   pri_q, sec_q;
  logic              slow_wrap, src_raw, src_tick, pri_tick;

  assign src       = src_e'(src_sel_i);
  assign slow_wrap = (slow_q == SLOW_W'(SLOW_DIV - 1));

  always_comb begin
    unique case (src)
      SRC_CASC: src_raw = casc_tick_i;
      SRC_CLK:  src_raw = 1'b1;
      SRC_SLOW: src_raw = slow_wrap;
      default:  src_raw = 1'b0;
    endcase
  end

  assign src_tick = src_raw & run_i & ~hold_i;
  assign pri_tick = src_tick & (pri_q == pri_div_i);
  assign tick_o   = pri_tick & (sec_q == sec_div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slow_q <= '0;
      pri_q  <= '0;
      sec_q  <= '0;
    end else if (hold_i) begin
      slow_q <= '0;
      pri_q  <= '0;
      sec_q  <= '0;
    end else if (run_i) begin
      if (src == SRC_SLOW)
        slow_q <= slow_wrap ? '0 : slow_q + SLOW_W'(1);
      if (src_tick)
        pri_q <= pri_tick ? '0 : pri_q + PS_W'(1);
      if (pri_tick)
        sec_q <= tick_o ? '0 : sec_q + PS_W'(1);
    end
  end

  // R3
  stop_phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !hold_i) |=> ($stable(pri_q) && $stable(sec_q) && $stable(slow_q)));

  // R4
  src_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src == SRC_OFF) |-> !tick_o);
endmodule

// File: rtl/drt_channel.sv
module drt_channel import drt_pkg::*; #(
  parameter int SLOW_DIV = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             casc_tick_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  logic [REG_W-1:0] mode_q, ref_q, cnt_q, cnt_nxt;
  logic [PS_W-1:0]  psr_q;
  logic             evt_q, tick, cnt_wr, evt_wr, match_set;

  assign cnt_wr = wr_i & (sel_i == REG_CNT);
  assign evt_wr = wr_i & (sel_i == REG_EVT);

  drt_prescaler #(.SLOW_DIV(SLOW_DIV)) u_psc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .hold_i      (hold_i),
    .src_sel_i   (mode_q[2:1]),
    .casc_tick_i (casc_tick_i),
    .pri_div_i   (psr_q),
    .sec_div_i   (mode_q[MODE_SPS_LO +: PS_W]),
    .tick_o      (tick)
  );

  assign cnt_nxt   = (mode_q[MODE_RESTART] && (cnt_q == ref_q)) ? '0 : cnt_q + REG_W'(1);
  assign match_set = tick & ~hold_i & ~cnt_wr & (cnt_nxt == ref_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ref_q  <= '0;
      psr_q  <= '0;
    end else if (wr_i) begin
      if (sel_i == REG_MODE) mode_q <= wdata_i;
      if (sel_i == REG_REF)  ref_q  <= wdata_i;
      if (sel_i == REG_PSR)  psr_q  <= wdata_i[PS_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (hold_i)  cnt_q <= '0;
    else if (cnt_wr)  cnt_q <= wdata_i;
    else if (tick)    cnt_q <= cnt_nxt;
  end

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              evt_q <= 1'b0;
    else if (match_set)                       evt_q <= 1'b1;
    else if (evt_wr && wdata_i[EVT_REF_BIT])  evt_q <= 1'b0;
  end

  assign irq_o = evt_q & mode_q[MODE_IRQ_EN];

  always_comb begin
    unique case (sel_i)
      REG_MODE: rdata_o = mode_q;
      REG_REF:  rdata_o = ref_q;
      REG_CNT:  rdata_o = cnt_q;
      REG_EVT:  rdata_o = REG_W'({evt_q, 1'b0});
      REG_PSR:  rdata_o = REG_W'(psr_q);
      default:  rdata_o = '0;
    endcase
  end

  // R2
  hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));

  // R3
  stop_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !hold_i && !cnt_wr) |=> $stable(cnt_q));

  // R7
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !hold_i && !cnt_wr && mode_q[MODE_RESTART] && (cnt_q == ref_q)) |=> (cnt_q == '0));

  // R6
  match_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(evt_q) && $stable(ref_q)) |-> (cnt_q == ref_q));

  // R10
  evt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q && !(evt_wr && wdata_i[EVT_REF_BIT])) |=> evt_q);
endmodule

// File: rtl/dual_ref_timer.sv
module dual_ref_timer import drt_pkg::*; #(
  parameter int SLOW_DIV = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEL_W:0]   addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic [1:0]       casc_tick_i,
  output logic [1:0]       irq_o
);
  localparam int NUM_TMR   = 2;
  localparam int CFG_W     = 8;
  localparam int CFG_PITCH = 4;

  logic [CFG_W-1:0] cfg_q;
  logic [REG_W-1:0] ch_rdata [NUM_TMR];
  logic             cfg_sel;

  assign cfg_sel = (addr_i[SEL_W-1:0] == REG_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cfg_q <= '0;
    else if (wr_i && cfg_sel && !addr_i[SEL_W]) cfg_q <= wdata_i[CFG_W-1:0];
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_ch
    logic en, stop;
    assign en   = cfg_q[CFG_PITCH*i];
    assign stop = cfg_q[CFG_PITCH*i+1];

    drt_channel #(.SLOW_DIV(SLOW_DIV)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (en & ~stop),
      .hold_i      (~en),
      .wr_i        (wr_i & ~cfg_sel & (addr_i[SEL_W] == 1'(i))),
      .sel_i       (addr_i[SEL_W-1:0]),
      .wdata_i     (wdata_i),
      .casc_tick_i (casc_tick_i[i]),
      .rdata_o     (ch_rdata[i]),
      .irq_o       (irq_o[i])
    );
  end

  always_comb begin
    if (cfg_sel) rdata_o = addr_i[SEL_W] ? '0 : REG_W'(cfg_q);
    else         rdata_o = ch_rdata[addr_i[SEL_W]];
  end

  // R2
  cfg_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(cfg_q));
endmodule

// File: tb/sim_dual_ref_timer.sv
`timescale 1ns/1ps
module sim_dual_ref_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  casc = '0;
  logic [1:0]  irq;
  logic [7:0]  cfg_sh = '0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dual_ref_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .casc_tick_i(casc), .irq_o(irq)
  );

  localparam logic [2:0] A_CFG = 0, A_MODE = 1, A_REF = 2, A_CNT = 3, A_EVT = 4, A_PSR = 5;
  localparam logic [15:0] M_CASC = 16'h0000, M_CLK = 16'h0002, M_SLOW = 16'h0004,
                          M_OFF = 16'h0006, M_RST = 16'h0008, M_IE = 16'h0010;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // called at a negedge: exactly one posedge commits the write
  task automatic wr_reg(input logic t, input logic [2:0] r, input logic [15:0] d);
    wr = 1'b1; addr = {t, r}; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic t, input logic [2:0] r, output logic [15:0] d);
    addr = {t, r};
    #1 d = rdata;
  endtask

  task automatic set_cfg(input logic [7:0] v);
    cfg_sh = v;
    wr_reg(1'b0, A_CFG, {8'h00, v});
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prog(input int t, input logic [15:0] mode, input logic [15:0] refv,
                      input logic [7:0] psr, input logic [15:0] cnt0);
    logic [7:0] en_b, st_b;
    en_b = 8'h01 << (4*t);
    st_b = 8'h02 << (4*t);
    set_cfg(cfg_sh & ~en_b);
    set_cfg(cfg_sh | en_b | st_b);
    wr_reg(1'(t), A_PSR, {8'h00, psr});
    wr_reg(1'(t), A_MODE, mode);
    wr_reg(1'(t), A_CNT, cnt0);
    wr_reg(1'(t), A_REF, refv);
    wr_reg(1'(t), A_EVT, 16'hFFFF);
    set_cfg(cfg_sh & ~st_b);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd_reg(0, A_CFG, d);  chk("R1 cfg", d, 16'h0000);
    rd_reg(0, A_CNT, d);  chk("R1 cnt0", d, 16'h0000);
    rd_reg(1, A_MODE, d); chk("R1 mode1", d, 16'h0000);
    chk("R1 irq", {14'b0, irq}, 16'h0000);
  endtask

  task automatic t_hold;
    logic [15:0] d;
    wr_reg(0, A_MODE, M_CLK);
    wr_reg(0, A_CNT, 16'h1234);
    run(10);
    rd_reg(0, A_CNT, d); chk("R2 held counter", d, 16'h0000);
  endtask

  task automatic t_regmap;
    logic [15:0] d;
    wr_reg(0, A_PSR, 16'hABCD);
    rd_reg(0, A_PSR, d); chk("R12 psr readback", d, 16'h00CD);
    set_cfg(8'h22);
    rd_reg(0, A_CFG, d); chk("R12 cfg readback", d, 16'h0022);
    rd_reg(1, A_CFG, d); chk("R12 timer1 cfg slot", d, 16'h0000);
    set_cfg(8'h00);
  endtask

  task automatic t_div1;
    logic [15:0] d;
    prog(0, M_CLK, 16'h0100, 8'd0, 16'h0000);
    run(10);
    rd_reg(0, A_CNT, d); chk("R5 div1 count", d, 16'd10);
  endtask

  task automatic t_div6_and_stop;
    logic [15:0] d;
    prog(0, M_CLK | 16'h0100, 16'h0100, 8'd2, 16'h0000);
    run(29);
    rd_reg(0, A_CNT, d); chk("R5 div6 before edge", d, 16'd4);
    run(1);
    rd_reg(0, A_CNT, d); chk("R5 div6 at edge", d, 16'd5);
    prog(0, M_CLK | 16'h0100, 16'h0100, 8'd2, 16'h0000);
    run(8);
    set_cfg(cfg_sh | 8'h02);          // this edge still counts: phase 9
    run(50);
    rd_reg(0, A_CNT, d); chk("R3 frozen while stopped", d, 16'd1);
    set_cfg(cfg_sh & ~8'h02);
    run(2);
    rd_reg(0, A_CNT, d); chk("R3 phase kept (11)", d, 16'd1);
    run(1);
    rd_reg(0, A_CNT, d); chk("R3 phase kept (12)", d, 16'd2);
  endtask

  task automatic t_slow;
    logic [15:0] d;
    prog(0, M_SLOW, 16'h0100, 8'd1, 16'h0000);
    run(63);
    rd_reg(0, A_CNT, d); chk("R4 slow before edge", d, 16'd1);
    run(1);
    rd_reg(0, A_CNT, d); chk("R4 slow at edge", d, 16'd2);
  endtask

  task automatic t_sources;
    logic [15:0] d;
    prog(0, M_CASC, 16'h0100, 8'd0, 16'h0000);
    run(5);
    for (int k = 0; k < 3; k++) begin
      casc[0] = 1'b1; @(negedge clk); casc[0] = 1'b0; @(negedge clk);
    end
    rd_reg(0, A_CNT, d); chk("R4 tick input count", d, 16'd3);
    prog(0, M_OFF, 16'h0100, 8'd0, 16'h0000);
    run(20);
    rd_reg(0, A_CNT, d); chk("R4 reserved source", d, 16'd0);
  endtask

  task automatic t_restart;
    logic [15:0] d;
    prog(0, M_CLK | M_RST | M_IE, 16'd4, 8'd0, 16'h0000);
    run(3);
    rd_reg(0, A_EVT, d); chk("R6 no event before match", d, 16'h0000);
    run(1);
    rd_reg(0, A_EVT, d); chk("R6 event at match", d, 16'h0002);
    chk("R9 irq on match", {15'b0, irq[0]}, 16'h0001);
    run(3);
    rd_reg(0, A_CNT, d); chk("R7 restarted count", d, 16'd2);
  endtask

  task automatic t_freerun_clear;
    logic [15:0] d;
    prog(0, M_CLK | M_IE, 16'd4, 8'd0, 16'h0000);
    run(7);
    rd_reg(0, A_CNT, d); chk("R8 counts through match", d, 16'd7);
    wr_reg(0, A_EVT, 16'h0001);
    rd_reg(0, A_EVT, d); chk("R10 zero bit keeps event", d, 16'h0002);
    chk("R9 irq held", {15'b0, irq[0]}, 16'h0001);
    wr_reg(0, A_EVT, 16'h0002);
    rd_reg(0, A_EVT, d); chk("R10 event cleared", d, 16'h0000);
    chk("R9 irq cleared", {15'b0, irq[0]}, 16'h0000);
    wr_reg(0, A_CNT, 16'h0100);
    rd_reg(0, A_CNT, d); chk("R11 write beats tick", d, 16'h0100);
  endtask

  task automatic t_irq_off;
    logic [15:0] d;
    prog(0, M_CLK, 16'd3, 8'd0, 16'h0000);
    run(5);
    rd_reg(0, A_EVT, d); chk("R9 event without enable", d, 16'h0002);
    chk("R9 irq masked", {15'b0, irq[0]}, 16'h0000);
  endtask

  task automatic t_wrap;
    logic [15:0] d;
    prog(0, M_CLK, 16'h0001, 8'd0, 16'hFFFD);
    run(3);
    rd_reg(0, A_CNT, d); chk("R8 wrapped to zero", d, 16'h0000);
    rd_reg(0, A_EVT, d); chk("R8 no early event", d, 16'h0000);
    run(1);
    rd_reg(0, A_CNT, d); chk("R11 preset then count", d, 16'h0001);
    rd_reg(0, A_EVT, d); chk("R6 event after wrap", d, 16'h0002);
  endtask

  task automatic t_pair;
    logic [15:0] d, c0;
    set_cfg(cfg_sh | 8'h02);
    rd_reg(0, A_CNT, c0);
    prog(1, M_CLK, 16'h0100, 8'd0, 16'h0000);
    run(12);
    rd_reg(1, A_CNT, d); chk("R2 timer1 counts", d, 16'd12);
    rd_reg(0, A_CNT, d); chk("R2 timer0 undisturbed", d, c0);
    rd_reg(0, A_CFG, d); chk("R2 cfg bits", d, 16'h0013);
  endtask

  initial begin
    run(3);
    t_reset();
    rst_n = 1'b1;
    run(2);
    t_reset();
    t_hold();
    t_regmap();
    t_div1();
    t_div6_and_stop();
    t_slow();
    t_sources();
    t_restart();
    t_freerun_clear();
    t_irq_off();
    t_wrap();
    t_pair();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule